// File: doc/BRIEF.md
# Attenuation-Aligned Gain Restoring Shifter

This block sits in a receive chain between the A/D converter and a CIC decimator. When the analog front end switches its step attenuator, it sends a 3-bit attenuation code, one unit per 6 dB. The samples that reflect the new attenuation reach the converter output some time later. That lag comes from attenuator settling, analog filter group delay and the converter pipeline. The block holds each code back by a programmable number of samples. It then applies the held code as a left shift of the sample, one bit per 6 dB, so that the digital gain cancels the analog attenuation on exactly the samples that were attenuated.

The delay is set as `dlySel`. The delay in samples is `dlySel + 1`, so it spans 1 to 256. Codes are stored in a circular buffer that advances only on valid samples, so the delay counts samples rather than idle clocks; with a continuous sample stream the two are the same. The output is widened to 21 bits so that a shift of seven never overflows. The restored gain therefore enters the filter with the full dynamic range of the mixer path.

Top module: `gain_realign_shifter`

## Requirements
- R1: While reset is asserted and after it is released with no valid sample yet, `outValid` is 0 and `outData` is 0.
- R2: `outValid` equals `inValid` delayed by exactly one clock.
- R3: For a valid sample, `outData` one clock later is the 14-bit two's complement `inSample` sign-extended to 21 bits and shifted left by the selected code value (0 to 7, one bit per 6 dB step). The product is exact, with no overflow or sign change, including for -8192 and 8191 at a shift of 7.
- R4: Number the valid samples from 0 after reset. The shift used for valid sample n is the `gainCode` captured with valid sample n-D, where D = `dlySel` + 1.
- R5: When n-D is negative, meaning fewer than D valid samples have been seen since reset, the shift is 0.
- R6: `gainCode` is captured only on cycles with `inValid` high. Values driven on other cycles have no effect on any later output.
- R7: On a cycle with `inValid` low, `outData` keeps its previous value one clock later.
- R8: A change of `dlySel` takes effect on the next valid sample and does not clear stored codes. After a change, sample n uses the code from sample n-D with the new D, including codes captured before the change.
- R9: The largest setting, `dlySel` = 255, gives D = 256. Each code reappears exactly 256 valid samples after it was captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inSample | input | 14 | A/D sample, two's complement |
| gainCode | input | 3 | Attenuation code, 6 dB per unit |
| dlySel | input | 8 | Code delay in samples, minus one |
| outValid | output | 1 | Output sample strobe |
| outData | output | 21 | Gain-restored sample, two's complement |

## Verification
A wrong pointer offset or a corrupted buffer entry shows up as a wrong power-of-two scale on `outData`. The error appears on the first valid sample whose code comes from that entry, which is at most 256 valid samples after the fault. A wrong reset of the buffer appears within the first D samples as a non-zero shift. A code captured on an idle cycle appears as a scale change D samples later. A lost or shifted strobe appears on `outValid` one clock after the input. The bench compares every clock against a history-list model, so each such fault is caught on the first sample it affects.

// File: rtl/gain_realign_pkg.sv
package gain_realign_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;  // store the incoming code and advance the ring
    logic launch;   // load the output register with the shifted sample
  } realign_stb_t;

endpackage

// File: rtl/gain_realign_ctrl.sv
module gain_realign_ctrl
  import gain_realign_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PTR_W-1:0] dlySel,
  output realign_stb_t     stb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr
);

  logic [PTR_W-1:0] wrPtrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtrQ <= '0;
    end else if (inValid) begin
      wrPtrQ <= wrPtrQ + PTR_W'(1);
    end
  end

  // The read slot lies D = dlySel+1 positions behind the slot being written.
  // With D equal to the ring size it is the slot about to be overwritten.
  always_comb begin
    rdPtr       = wrPtrQ - dlySel - PTR_W'(1);
    wrPtr       = wrPtrQ;
    stb.capture = inValid;
    stb.launch  = inValid;
  end

endmodule

// File: rtl/gain_realign_dp.sv
module gain_realign_dp
  import gain_realign_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int CODE_W   = 3,
  parameter int DEPTH    = 256,
  parameter int PTR_W    = 8,
  parameter int OUT_W    = 21
) (
  input  logic                clk,
  input  logic                rstN,
  input  realign_stb_t        stb,
  input  logic [PTR_W-1:0]    wrPtr,
  input  logic [PTR_W-1:0]    rdPtr,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [CODE_W-1:0]   gainCode,
  output logic                outValid,
  output logic [OUT_W-1:0]    outData
);

  localparam int NUM_SHIFT = 1 << CODE_W;
  localparam int EXT_W     = OUT_W - SAMPLE_W;

  logic [CODE_W-1:0] codeRing [DEPTH];
  logic [CODE_W-1:0] heldCode;
  logic [OUT_W-1:0]  extSample;
  logic [OUT_W-1:0]  shiftCand [NUM_SHIFT];
  logic [OUT_W-1:0]  shifted;

  // Code delay ring; the read happens before the write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) codeRing[i] <= '0;
    end else if (stb.capture) begin
      codeRing[wrPtr] <= gainCode;
    end
  end

  assign heldCode  = codeRing[rdPtr];
  assign extSample = {{EXT_W{inSample[SAMPLE_W-1]}}, inSample};

  // One candidate per shift amount, then a single select
  for (genvar s = 0; s < NUM_SHIFT; s++) begin : g_shift
    assign shiftCand[s] = extSample << s;
  end

  assign shifted = shiftCand[heldCode];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= stb.launch;
      if (stb.launch) outData <= shifted;
    end
  end

endmodule

// File: rtl/gain_realign_shifter.sv
module gain_realign_shifter
  import gain_realign_pkg::*;
#(
  parameter int SAMPLE_W  = 14,
  parameter int CODE_W    = 3,
  parameter int MAX_DELAY = 256   // power of two; ring wraps naturally
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         inValid,
  input  logic [SAMPLE_W-1:0]                          inSample,
  input  logic [CODE_W-1:0]                            gainCode,
  input  logic [$clog2(MAX_DELAY)-1:0]                 dlySel,
  output logic                                         outValid,
  output logic [SAMPLE_W+(1<<CODE_W)-2:0]              outData
);

  localparam int PTR_W     = $clog2(MAX_DELAY);
  localparam int MAX_SHIFT = (1 << CODE_W) - 1;
  localparam int OUT_W     = SAMPLE_W + MAX_SHIFT;

  realign_stb_t     stb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  gain_realign_ctrl #(
    .PTR_W(PTR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .dlySel (dlySel),
    .stb    (stb),
    .wrPtr  (wrPtr),
    .rdPtr  (rdPtr)
  );

  gain_realign_dp #(
    .SAMPLE_W(SAMPLE_W),
    .CODE_W  (CODE_W),
    .DEPTH   (MAX_DELAY),
    .PTR_W   (PTR_W),
    .OUT_W   (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrPtr   (wrPtr),
    .rdPtr   (rdPtr),
    .inSample(inSample),
    .gainCode(gainCode),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: rtl/gain_realign_chk.sv
module gain_realign_chk #(
  parameter int SAMPLE_W = 14,
  parameter int OUT_W    = 21
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inSample,
  input logic                outValid,
  input logic [OUT_W-1:0]    outData
);

  // R2: strobe follows input one clock later
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7: idle cycles leave the output word alone
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

  // R3: shifting never flips the sign
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outData[OUT_W-1] == $past(inSample[SAMPLE_W-1]));

  // R3: zero stays zero at any shift
  a_r3_zero_in: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSample == '0) |=> outData == '0);

endmodule

bind gain_realign_shifter gain_realign_chk #(
  .SAMPLE_W(SAMPLE_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inSample(inSample),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/gain_realign_shifter_tb.sv
`timescale 1ns/1ps
module gain_realign_shifter_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [13:0] inSample;
  logic [2:0]  gainCode;
  logic [7:0]  dlySel;
  logic        outValid;
  logic [20:0] outData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int hist[$];
  int dly;
  int expOut;
  bit expValid;

  always #2 clk = ~clk;

  gain_realign_shifter u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .gainCode(gainCode), .dlySel(dlySel), .outValid(outValid), .outData(outData)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle, update the model, compare after the edge
  task automatic cyc(bit v, int smp, int code, string tag);
    inValid  = v;
    inSample = smp[13:0];
    gainCode = code[2:0];
    dlySel   = 8'(dly - 1);
    if (v) begin
      int n  = hist.size();
      int sh = (n - dly >= 0) ? hist[n - dly] : 0;
      expOut = smp * (1 << sh);
      hist.push_back(code);
    end
    expValid = v;
    @(posedge clk);
    @(negedge clk);
    check(outValid == expValid, "R2", int'(outValid), int'(expValid));
    check($signed(outData) == expOut, v ? tag : "R7", int'($signed(outData)), expOut);
  endtask

  function automatic int rndSmp();
    return int'($urandom_range(0, 16383)) - 8192;
  endfunction

  initial begin
    rstN = 1'b0; inValid = 1'b0; inSample = '0; gainCode = '0; dlySel = '0;
    dly = 1; expOut = 0; expValid = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outData == '0, "R1", int'(outData), 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outData == '0, "R1", int'(outData), 0);

    // R5 then R4: first D samples see shift 0
    dly = 4;
    for (int i = 0; i < 4; i++) cyc(1, rndSmp(), 7, "R5");
    for (int i = 0; i < 30; i++) cyc(1, rndSmp(), int'($urandom_range(0, 7)), "R4");

    // R3: extremes at the largest shift
    dly = 1;
    for (int i = 0; i < 40; i++) begin
      int s = (i % 4 == 0) ? -8192 : (i % 4 == 1) ? 8191 : (i % 4 == 2) ? -1 : rndSmp();
      cyc(1, s, 7, "R3");
    end
    for (int i = 0; i < 16; i++) cyc(1, (i % 2) ? 8191 : -8192, i % 8, "R3");

    // R6/R7: gaps with codes toggling on idle cycles
    dly = 6;
    for (int i = 0; i < 120; i++) begin
      bit v = ($urandom_range(0, 1) == 1);
      cyc(v, rndSmp(), int'($urandom_range(0, 7)), "R6");
    end

    // R8: delay changes without clearing history
    for (int k = 0; k < 8; k++) begin
      int sel = k % 4;
      dly = (sel == 0) ? 5 : (sel == 1) ? 17 : (sel == 2) ? 3 : 64;
      for (int i = 0; i < 20; i++) cyc(1, rndSmp(), int'($urandom_range(0, 7)), "R8");
    end

    // R9: longest delay, with a few gaps
    dly = 256;
    for (int i = 0; i < 700; i++) begin
      bit v = (i % 37 != 0);
      cyc(v, rndSmp(), int'($urandom_range(0, 7)), "R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule